// File: doc/BRIEF.md
# USB NRZI Line Encoder

This block is the last stage of a USB transmit path before the transceiver. Each cycle it takes one serial symbol request and turns it into registered D+ and D- line levels and a registered output enable. A request is made of four inputs: a valid strobe, an output-enable request, a data bit and an SE0 request. The block keeps a one-bit NRZI line level. A data bit of 0 flips the level between J and K. A data bit of 1 leaves the level where it is.

An SE0 request wins over the data bit and pulls both lines low. It comes out with the same one-clock latency as encoded data, so end-of-packet timing stays in step with the bit stream. When the output-enable request is low, the block releases the bus and drives the idle (J) levels. Both an SE0 and a released bus put the NRZI level back to J, so every packet starts from idle.

The block runs in the 48 MHz bit domain. A parameter selects the full-speed or the low-speed meaning of J and K.

Top module: `usb_nrzi_line_enc`

## Requirements
- R1: While reset is held and right after it, with FULL_SPEED=1, line_dp is 1, line_dm is 0 and line_oe is 0. This is the idle J state with the bus released.
- R2: In a cycle with tx_valid low, tx_oe, tx_bit and tx_se0 have no effect. At the next clock, line_dp, line_dm and line_oe keep their values, and the internal NRZI level is unchanged. The bench checks this through the next encoded data bit.
- R3: A valid data request (tx_oe=1, tx_se0=0) with tx_bit=0 switches the line to the opposite state. J is dp=1,dm=0 and K is dp=0,dm=1 at full speed. line_oe is 1.
- R4: A valid data request with tx_bit=1 repeats the present line state, and line_oe is 1.
- R5: A valid request with tx_oe=1 and tx_se0=1 drives line_dp=0 and line_dm=0 with line_oe=1, whatever the value of tx_bit.
- R6: After an SE0 or a bus release, the next valid data bit is encoded starting from J. A 1 gives J and a 0 gives K.
- R7: A valid request with tx_oe=0 drives line_oe=0 and the J levels, whatever the values of tx_bit and tx_se0.
- R8: The outputs are registered. A valid request shows up on the outputs at the first rising clock edge after it is presented, and not earlier.
- R9: line_dp and line_dm are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 48 MHz bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid | input | 1 | Qualifies the other three request inputs |
| tx_oe | input | 1 | Request to drive the bus |
| tx_bit | input | 1 | Serial data bit to NRZI-encode |
| tx_se0 | input | 1 | Request to drive SE0 in place of data |
| line_dp | output | 1 | Registered D+ level |
| line_dm | output | 1 | Registered D- level |
| line_oe | output | 1 | Registered transmit enable for the transceiver |

## Verification
The checker assumes that tx_valid, tx_oe, tx_bit and tx_se0 are settled and known at each rising edge once reset is released. It places no limit on the order of requests: SE0 may come straight after data, valid may drop at any point, and the bus may be released while the line sits in K. The bench changes its inputs only on falling edges and never leaves an input at X. Its directed runs and its random run both mix invalid, idle, SE0 and data cycles freely, so every property is reached from both J and K.

// File: rtl/usb_line_pkg.sv
// Package: shared types for the USB transmit line encoder.
// Assumes: one symbol request per clock, bit-rate clock domain.
package usb_line_pkg;

    // Kind of request presented to the encoder in one cycle.
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,  // no valid request: keep everything
        CMD_IDLE = 2'd1,  // release the bus, line parks at J
        CMD_SE0  = 2'd2,  // drive single-ended zero
        CMD_DATA = 2'd3   // NRZI-encode one data bit
    } tx_cmd_e;

    // Differential symbol to place on the bus.
    typedef enum logic [1:0] {
        LINE_J   = 2'd0,
        LINE_K   = 2'd1,
        LINE_SE0 = 2'd2
    } line_sym_e;

    // Raw pin pair.
    typedef struct packed {
        logic dp;
        logic dm;
    } pin_pair_t;

endpackage

// File: rtl/usb_tx_cmd_decode.sv
// Module: usb_tx_cmd_decode
// Turns the four request inputs into one command. SE0 takes priority over
// data, and a low output-enable request takes priority over both.
// Assumes: inputs are only meaningful when valid is high.
module usb_tx_cmd_decode
    import usb_line_pkg::*;
(
    input  logic    valid_i,
    input  logic    oe_i,
    input  logic    se0_i,
    output tx_cmd_e cmd_o
);

    // Priority decode: invalid, then release, then SE0, then data.
    always_comb begin
        if (!valid_i) begin
            cmd_o = CMD_HOLD;
        end else if (!oe_i) begin
            cmd_o = CMD_IDLE;
        end else if (se0_i) begin
            cmd_o = CMD_SE0;
        end else begin
            cmd_o = CMD_DATA;
        end
    end

endmodule

// File: rtl/usb_nrzi_level.sv
// Module: usb_nrzi_level
// Holds the NRZI line level (J or K) and works out the symbol for this
// cycle's command. A data 0 flips the level and a data 1 keeps it. SE0 and
// release both put the level back to J.
// Assumes: synchronous active-low reset; the symbol output is only used
// when the command is not HOLD.
module usb_nrzi_level
    import usb_line_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tx_cmd_e   cmd_i,
    input  logic      bit_i,
    output line_sym_e sym_o
);

    logic level_q;   // 0 = J, 1 = K
    logic level_d;

    // Next NRZI level for each command.
    always_comb begin
        unique case (cmd_i)
            CMD_DATA: level_d = bit_i ? level_q : ~level_q;
            CMD_SE0:  level_d = 1'b0;
            CMD_IDLE: level_d = 1'b0;
            default:  level_d = level_q;
        endcase
    end

    // Level register, starts at J.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_d;
        end
    end

    // Symbol for the line: SE0 overrides the encoded level.
    always_comb begin
        if (cmd_i == CMD_SE0) begin
            sym_o = LINE_SE0;
        end else if (level_d) begin
            sym_o = LINE_K;
        end else begin
            sym_o = LINE_J;
        end
    end

endmodule

// File: rtl/usb_line_map.sv
// Module: usb_line_map
// Maps a line symbol to raw D+/D- levels. FULL_SPEED picks the polarity of
// J and K: at full speed J has D+ high, at low speed J has D- high.
// Assumes: purely combinational; SE0 is the same at both speeds.
module usb_line_map
    import usb_line_pkg::*;
#(
    parameter bit FULL_SPEED = 1'b1
) (
    input  line_sym_e sym_i,
    output pin_pair_t pins_o
);

    generate
        if (FULL_SPEED) begin : g_full
            // Full-speed polarity.
            always_comb begin
                unique case (sym_i)
                    LINE_J:  pins_o = '{dp: 1'b1, dm: 1'b0};
                    LINE_K:  pins_o = '{dp: 1'b0, dm: 1'b1};
                    default: pins_o = '{dp: 1'b0, dm: 1'b0};
                endcase
            end
        end else begin : g_low
            // Low-speed polarity.
            always_comb begin
                unique case (sym_i)
                    LINE_J:  pins_o = '{dp: 1'b0, dm: 1'b1};
                    LINE_K:  pins_o = '{dp: 1'b1, dm: 1'b0};
                    default: pins_o = '{dp: 1'b0, dm: 1'b0};
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/usb_line_oreg.sv
// Module: usb_line_oreg
// Output flops for D+, D- and output enable. They load only on a valid
// request and hold otherwise, so the pins never glitch between requests.
// Assumes: synchronous active-low reset to the idle J pattern, bus released.
module usb_line_oreg
    import usb_line_pkg::*;
#(
    parameter logic RST_DP = 1'b1,
    parameter logic RST_DM = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  pin_pair_t pins_i,
    input  logic      oe_i,
    output logic      dp_o,
    output logic      dm_o,
    output logic      oe_o
);

    // Register the line state on each valid request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_o <= RST_DP;
            dm_o <= RST_DM;
            oe_o <= 1'b0;
        end else if (load_i) begin
            dp_o <= pins_i.dp;
            dm_o <= pins_i.dm;
            oe_o <= oe_i;
        end
    end

endmodule

// File: rtl/usb_nrzi_line_enc.sv
// Module: usb_nrzi_line_enc (top)
// Encodes a qualified serial transmit stream into registered USB D+/D-
// levels and an output enable. All outputs change one clock after a valid
// request and hold during invalid cycles.
// Assumes: one request per clock in the bit-rate domain, synchronous
// active-low reset.
module usb_nrzi_line_enc
    import usb_line_pkg::*;
#(
    parameter bit FULL_SPEED = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_valid,
    input  logic tx_oe,
    input  logic tx_bit,
    input  logic tx_se0,
    output logic line_dp,
    output logic line_dm,
    output logic line_oe
);

    localparam logic IDLE_DP = FULL_SPEED ? 1'b1 : 1'b0;
    localparam logic IDLE_DM = ~IDLE_DP;

    tx_cmd_e   cmd;
    line_sym_e sym;
    pin_pair_t pins;
    logic      load;
    logic      drive;

    usb_tx_cmd_decode u_dec (
        .valid_i (tx_valid),
        .oe_i    (tx_oe),
        .se0_i   (tx_se0),
        .cmd_o   (cmd)
    );

    usb_nrzi_level u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd_i (cmd),
        .bit_i (tx_bit),
        .sym_o (sym)
    );

    usb_line_map #(.FULL_SPEED(FULL_SPEED)) u_map (
        .sym_i  (sym),
        .pins_o (pins)
    );

    // Load on any valid request; drive the bus for data and SE0.
    always_comb begin
        load  = (cmd != CMD_HOLD);
        drive = (cmd == CMD_DATA) || (cmd == CMD_SE0);
    end

    usb_line_oreg #(.RST_DP(IDLE_DP), .RST_DM(IDLE_DM)) u_oreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .pins_i (pins),
        .oe_i   (drive),
        .dp_o   (line_dp),
        .dm_o   (line_dm),
        .oe_o   (line_oe)
    );

endmodule

// File: rtl/usb_nrzi_line_enc_chk.sv
// Module: usb_nrzi_line_enc_chk
// Property checker for the line encoder, bound to the top module.
// Assumes: request inputs are known at every rising edge out of reset.
module usb_nrzi_line_enc_chk #(
    parameter bit FULL_SPEED = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_oe,
    input logic tx_bit,
    input logic tx_se0,
    input logic line_dp,
    input logic line_dm,
    input logic line_oe
);

    localparam logic J_DP = FULL_SPEED ? 1'b1 : 1'b0;
    localparam logic J_DM = ~J_DP;

    logic past_ok;

    // Marks that the previous edge was out of reset, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !past_ok && rst_n |-> line_dp == J_DP && line_dm == J_DM && !line_oe); // R1

    AST_NO_DUAL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_dp && line_dm)); // R9

    AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(tx_valid) |->
            $stable(line_dp) && $stable(line_dm) && $stable(line_oe)); // R2

    AST_DATA0_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(tx_valid && tx_oe && !tx_se0 && !tx_bit)
            && $past(line_oe && (line_dp != line_dm)) |->
            line_oe && line_dp != $past(line_dp) && line_dm != $past(line_dm)); // R3

    AST_DATA1_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(tx_valid && tx_oe && !tx_se0 && tx_bit)
            && $past(line_oe && (line_dp != line_dm)) |->
            line_oe && $stable(line_dp) && $stable(line_dm)); // R4

    AST_SE0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(tx_valid && tx_oe && tx_se0) |->
            !line_dp && !line_dm && line_oe); // R5

    AST_RESTART_FROM_J: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(tx_valid && tx_oe && !tx_se0)
            && $past(!line_oe || (!line_dp && !line_dm)) |->
            line_dp == ($past(tx_bit) ? J_DP : J_DM)); // R6

    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(tx_valid && !tx_oe) |->
            !line_oe && line_dp == J_DP && line_dm == J_DM); // R7

endmodule

bind usb_nrzi_line_enc usb_nrzi_line_enc_chk #(.FULL_SPEED(FULL_SPEED)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_oe    (tx_oe),
    .tx_bit   (tx_bit),
    .tx_se0   (tx_se0),
    .line_dp  (line_dp),
    .line_dm  (line_dm),
    .line_oe  (line_oe)
);

// File: tb/tb_usb_nrzi_line_enc.sv
module tb_usb_nrzi_line_enc;

    localparam int CLK_PERIOD = 10;
    localparam logic J_DP = 1'b1;
    localparam logic J_DM = 1'b0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_valid = 1'b0;
    logic tx_oe = 1'b0;
    logic tx_bit = 1'b0;
    logic tx_se0 = 1'b0;
    logic line_dp;
    logic line_dm;
    logic line_oe;

    typedef struct {
        logic  dp;
        logic  dm;
        logic  oe;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t last_exp;
    logic model_k = 1'b0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    usb_nrzi_line_enc #(.FULL_SPEED(1'b1)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_valid (tx_valid),
        .tx_oe    (tx_oe),
        .tx_bit   (tx_bit),
        .tx_se0   (tx_se0),
        .line_dp  (line_dp),
        .line_dm  (line_dm),
        .line_oe  (line_oe)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual dp,dm,oe=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: present one request at a falling edge and push its expected result.
    task automatic drive(input logic v, input logic o, input logic d, input logic s);
        exp_t e;
        @(negedge clk);
        tx_valid = v; tx_oe = o; tx_bit = d; tx_se0 = s;
        e = last_exp;
        if (!v) begin
            e.tag = "R2";                        // invalid: all outputs hold
        end else if (!o) begin
            model_k = 1'b0;
            e.dp = J_DP; e.dm = J_DM; e.oe = 1'b0;
            e.tag = "R7";
        end else if (s) begin
            model_k = 1'b0;
            e.dp = 1'b0; e.dm = 1'b0; e.oe = 1'b1;
            e.tag = "R5";
        end else begin
            if (!(last_exp.oe && (last_exp.dp != last_exp.dm))) e.tag = "R6";
            else if (d) e.tag = "R4";
            else e.tag = "R3";
            if (!d) model_k = ~model_k;
            e.dp = model_k ? J_DM : J_DP;
            e.dm = ~e.dp;
            e.oe = 1'b1;
        end
        sb_q.push_back(e);
        // R8: nothing may change before the next rising edge
        #(CLK_PERIOD / 2 - 1);
        check("R8", {line_dp, line_dm, line_oe}, {last_exp.dp, last_exp.dm, last_exp.oe});
        last_exp = e;
    endtask

    // Monitor: pop and compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, {line_dp, line_dm, line_oe}, {e.dp, e.dm, e.oe});
                check("R9", {1'b0, 1'b0, line_dp & line_dm}, 3'b000);
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {line_dp, line_dm, line_oe}, {J_DP, J_DM, 1'b0});
        rst_n = 1'b1;
        last_exp.dp = J_DP; last_exp.dm = J_DM; last_exp.oe = 1'b0; last_exp.tag = "R1";
        @(posedge clk);
        #1;
        check("R1", {line_dp, line_dm, line_oe}, {J_DP, J_DM, 1'b0});

        // Packet from idle: first bit R6, then toggles R3 and holds R4.
        drive(1, 1, 0, 0);
        drive(1, 1, 0, 0);
        drive(1, 1, 1, 0);
        drive(1, 1, 1, 0);
        drive(1, 1, 0, 0);
        // R2: invalid cycles with every other input waving
        drive(0, 0, 1, 1);
        drive(0, 1, 0, 1);
        drive(0, 0, 0, 0);
        drive(1, 1, 0, 0);
        drive(1, 1, 1, 0);
        // R5: SE0 overrides both bit values
        drive(1, 1, 1, 1);
        drive(1, 1, 0, 1);
        drive(0, 1, 0, 0);
        // R6: next data starts from J after SE0
        drive(1, 1, 0, 0);
        drive(1, 1, 0, 0);
        drive(1, 1, 0, 1);
        drive(1, 1, 1, 0);
        // R7: release from K with se0 and bit set, then restart
        drive(1, 1, 0, 0);
        drive(1, 0, 1, 1);
        drive(0, 1, 0, 0);
        drive(1, 1, 1, 0);
        drive(1, 0, 0, 0);
        drive(1, 1, 0, 0);

        // Random mix of all request kinds.
        for (int i = 0; i < 400; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            drive(r[0] | r[1], r[1] | r[2] | r[3], r[2], r[3] & r[0] & r[1]);
        end

        drive(0, 0, 0, 0);
        repeat (2) @(posedge clk);
        #2;
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL R8 actual pending=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule